// File: doc/BRIEF.md
# Integer-Ratio Clock Multiplier PLL

This block is an all-digital phase-locked loop that derives a fast clock-enable stream from a slow reference pulse train. The output rate is a fixed integer multiple of the reference rate, 1000 by default, which turns an 8 kHz reference into an 8 MHz enable. Everything runs on one free-running system clock. A numerically controlled oscillator (a phase accumulator) produces the enable. A counter divides that enable by the ratio. A phase/frequency detector times the divided edge against the synchronised reference edge. A proportional-integral filter then corrects the oscillator's tuning word.

A system integrator sets the nominal tuning word to the expected ratio of output rate to system rate, scaled by 2^TW_W. The loop gains are set as power-of-two shifts, and the integrator limit and the detector window are set as parameters. At run time the integrator programs the lock threshold on its port. Downstream logic uses `clk_en_o` as the multiplied clock and `locked_o` to know when it can be trusted. The divided pulse and the live tuning word are also exposed.

Top module: `ckmul_pll`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the tuning word equals NOM_TW, the lock flag is low and neither pulse output is high.
- R2: Every system clock, the tuning word is added modulo 2^TW_W to a TW_W-bit accumulator. `clk_en_o` is high for exactly one cycle each time the accumulator's top bit goes from 0 to 1. The tuning word always stays within 1 to 2^(TW_W-1)-1, so enables are never adjacent.
- R3: `fb_pulse_o` is high together with every DIV_N-th enable. Counting from one feedback pulse up to and including the next one, there are exactly DIV_N enables (the first feedback pulse is the DIV_N-th enable after reset).
- R4: The reference passes through two synchroniser flops and then a rising-edge detector. Zero phase error means that a feedback pulse appears in the cycle that follows the second clock edge after the first edge that samples the reference high.
- R5: The detector reports a signed count of system clocks between a reference edge and its partner feedback edge. The count is positive when the reference edge comes first, negative when the feedback edge comes first, and zero when both edges fall in the same cycle. If the partner edge does not arrive within SAT_CYC cycles, or a second edge of the leading kind arrives first, the detector reports ±SAT_CYC.
- R6: On each measurement e, the integrator becomes clamp(integ + e·2^KI_SH, ±INT_LIM). The tuning word then becomes NOM_TW + e·2^KP_SH + the new integrator value, clamped to the R2 range. Between measurements the tuning word does not change.
- R7: The lock flag rises on the LOCK_GOOD-th (16) consecutive measurement whose magnitude is below `lock_thresh_i`. It updates on the same edge as the tuning word, so it can never rise earlier than 15 reference periods after the reference starts.
- R8: The lock flag falls on the LOCK_BAD-th (4) consecutive measurement whose magnitude is at or above `lock_thresh_i`. A threshold of 0 therefore unlocks a running loop after exactly four measurements.
- R9: Once locked with a steady reference, every feedback pulse lies within the threshold of the zero-error position of R4. Over any 32 reference periods, the loop delivers exactly 32 feedback pulses and 32·DIV_N ± 1 enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Slow reference pulse train, asynchronous |
| lock_thresh_i | input | THR_W | Lock threshold in system clocks |
| clk_en_o | output | 1 | Multiplied clock-enable, one cycle wide |
| fb_pulse_o | output | 1 | Enable divided by DIV_N |
| tune_word_o | output | TW_W | Current oscillator tuning word |
| locked_o | output | 1 | Lock indicator with hysteresis |

## Verification
At lock, the synchronised reference edge and the divided feedback edge land in the same system cycle. This is the detector's both-edges-at-once path, and it must give an error of zero rather than starting a new measurement. The bench provokes it by running a steady reference until lock. It judges the result by the offset of each feedback pulse from the computed zero-error cycle and by the pulse counts over a 32-period window. A second overlap is the detector's saturation ending a measurement in the same cycle as the filter and lock monitor act on it. This is driven by withdrawing the reference and comparing each new tuning word, and the lock flag on that same edge, with values computed from the gains.

// File: rtl/ckmul_pkg.sv
package ckmul_pkg;

    // Detector state: which edge opened the current measurement
    typedef enum logic [1:0] {
        PFD_IDLE     = 2'd0,
        PFD_REF_LEAD = 2'd1,
        PFD_FB_LEAD  = 2'd2
    } pfd_state_e;

endpackage

// File: rtl/ckmul_refpfd.sv
module ckmul_refpfd
    import ckmul_pkg::*;
#(
    parameter int SAT_CYC = 15625,
    parameter int ERR_W   = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    ref_i,
    input  logic                    fb_pulse_i,
    output logic                    err_vld_o,
    output logic signed [ERR_W-1:0] err_o
);

    localparam int CNT_W = $clog2(SAT_CYC + 1);
    localparam logic [CNT_W-1:0]        SAT_CNT = CNT_W'(SAT_CYC);
    localparam logic signed [ERR_W-1:0] SAT_POS = ERR_W'(SAT_CYC);
    localparam logic signed [ERR_W-1:0] SAT_NEG = -ERR_W'(SAT_CYC);

    typedef struct packed {
        logic [2:0]              sync;
        pfd_state_e              st;
        logic [CNT_W-1:0]        cnt;
        logic                    vld;
        logic signed [ERR_W-1:0] err;
    } pfd_t;

    pfd_t q, d;
    logic ref_edge;

    // sync[0], sync[1] form the synchroniser; sync[2] is the edge history
    assign ref_edge = q.sync[1] & ~q.sync[2];

    always_comb begin
        d      = q;
        d.sync = {q.sync[1:0], ref_i};
        d.vld  = 1'b0;
        unique case (q.st)
            PFD_IDLE: begin
                if (ref_edge && fb_pulse_i) begin
                    d.vld = 1'b1;
                    d.err = '0;
                end else if (ref_edge) begin
                    d.st  = PFD_REF_LEAD;
                    d.cnt = CNT_W'(1);
                end else if (fb_pulse_i) begin
                    d.st  = PFD_FB_LEAD;
                    d.cnt = CNT_W'(1);
                end
            end
            PFD_REF_LEAD: begin
                if (fb_pulse_i) begin
                    d.vld = 1'b1;
                    d.err = ERR_W'(q.cnt);
                    d.st  = PFD_IDLE;
                end else if (ref_edge || q.cnt == SAT_CNT) begin
                    d.vld = 1'b1;
                    d.err = SAT_POS;
                    d.st  = PFD_IDLE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            PFD_FB_LEAD: begin
                if (ref_edge) begin
                    d.vld = 1'b1;
                    d.err = -ERR_W'(q.cnt);
                    d.st  = PFD_IDLE;
                end else if (fb_pulse_i || q.cnt == SAT_CNT) begin
                    d.vld = 1'b1;
                    d.err = SAT_NEG;
                    d.st  = PFD_IDLE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: d.st = PFD_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{sync: '0, st: PFD_IDLE, cnt: '0, vld: 1'b0, err: '0};
        end else begin
            q <= d;
        end
    end

    assign err_vld_o = q.vld;
    assign err_o     = q.err;

    // R5: a reported error never exceeds the detector window
    a_r5_err_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_vld_o |-> (err_o <= SAT_POS && err_o >= SAT_NEG));

    // R5: an open measurement always closes by the window end
    a_r5_window_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st != PFD_IDLE && q.cnt == SAT_CNT) |=> (q.st == PFD_IDLE && q.vld));

    // R4: a measurement only opens from idle on a detected edge
    a_r4_open_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(q.st) == PFD_IDLE && q.st == PFD_REF_LEAD) |-> $past(ref_edge));

endmodule

// File: rtl/ckmul_nco.sv
module ckmul_nco #(
    parameter int TW_W  = 32,
    parameter int DIV_N = 1000
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [TW_W-1:0] tw_i,
    output logic            pulse_o,
    output logic            fb_o
);

    localparam int DIV_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_N - 1);

    typedef struct packed {
        logic [TW_W-1:0]  acc;
        logic             msb;
        logic [DIV_W-1:0] div;
    } nco_t;

    nco_t q, d;
    logic pulse;

    assign pulse = q.acc[TW_W-1] & ~q.msb;

    always_comb begin
        d     = q;
        d.acc = q.acc + tw_i;
        d.msb = q.acc[TW_W-1];
        if (pulse) begin
            d.div = (q.div == DIV_LAST) ? '0 : q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pulse_o = pulse;
    assign fb_o    = pulse && (q.div == DIV_LAST);

    // R2: the enable is a single-cycle pulse
    a_r2_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);

    // R3: after a feedback pulse the divider restarts from zero
    a_r3_div_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fb_o |=> (q.div == '0));

    // R3: the divider moves only on an enable
    a_r3_div_moves_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pulse_o |=> $stable(q.div));

endmodule

// File: rtl/ckmul_pi.sv
module ckmul_pi #(
    parameter int              TW_W    = 32,
    parameter int              ERR_W   = 16,
    parameter logic [TW_W-1:0] NOM_TW  = 32'd137438953,
    parameter int              KP_SH   = 11,
    parameter int              KI_SH   = 7,
    parameter int              INT_LIM = 1 << 24
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    err_vld_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic [TW_W-1:0]         tw_o
);

    localparam int CW = TW_W + 16;
    localparam logic signed [CW-1:0] ILIM_P = CW'(INT_LIM);
    localparam logic signed [CW-1:0] ILIM_N = -CW'(INT_LIM);
    localparam logic signed [CW-1:0] NOM_C  = CW'(NOM_TW);
    localparam logic signed [CW-1:0] TW_MAX = (CW'(1) <<< (TW_W - 1)) - CW'(1);
    localparam logic signed [CW-1:0] TW_MIN = CW'(1);

    typedef struct packed {
        logic signed [CW-1:0] integ;
        logic [TW_W-1:0]      tw;
    } pi_t;

    pi_t q, d;
    logic signed [CW-1:0] e_ext;
    logic signed [CW-1:0] p_term;
    logic signed [CW-1:0] i_sum;
    logic signed [CW-1:0] t_sum;

    always_comb begin
        d      = q;
        e_ext  = CW'(err_i);
        p_term = e_ext <<< KP_SH;
        i_sum  = q.integ + (e_ext <<< KI_SH);
        if (i_sum > ILIM_P) begin
            i_sum = ILIM_P;
        end else if (i_sum < ILIM_N) begin
            i_sum = ILIM_N;
        end
        t_sum = NOM_C + p_term + i_sum;
        if (t_sum > TW_MAX) begin
            t_sum = TW_MAX;
        end else if (t_sum < TW_MIN) begin
            t_sum = TW_MIN;
        end
        if (err_vld_i) begin
            d.integ = i_sum;
            d.tw    = t_sum[TW_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{integ: '0, tw: NOM_TW};
        end else begin
            q <= d;
        end
    end

    assign tw_o = q.tw;

    // R6: integrator never leaves its clamp
    a_r6_integ_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.integ <= ILIM_P && q.integ >= ILIM_N));

    // R6: tuning word holds between measurements
    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !err_vld_i |=> $stable(tw_o));

    // R2: tuning word stays in the legal oscillator range
    a_r2_tw_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tw_o != '0 && tw_o[TW_W-1] == 1'b0));

endmodule

// File: rtl/ckmul_lockmon.sv
module ckmul_lockmon #(
    parameter int ERR_W     = 16,
    parameter int THR_W     = 16,
    parameter int LOCK_GOOD = 16,
    parameter int LOCK_BAD  = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    err_vld_i,
    input  logic signed [ERR_W-1:0] err_i,
    input  logic [THR_W-1:0]        thresh_i,
    output logic                    locked_o
);

    localparam int GW = $clog2(LOCK_GOOD + 1);
    localparam int BW = $clog2(LOCK_BAD + 1);
    localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_GOOD - 1);
    localparam logic [BW-1:0] BAD_LAST  = BW'(LOCK_BAD - 1);

    typedef struct packed {
        logic [GW-1:0] good;
        logic [BW-1:0] bad;
        logic          lock;
    } lk_t;

    lk_t q, d;
    logic [ERR_W-1:0] mag;
    logic             in_win;

    always_comb begin
        d      = q;
        mag    = err_i[ERR_W-1] ? ERR_W'(-err_i) : ERR_W'(err_i);
        in_win = (32'(mag) < 32'(thresh_i));
        if (err_vld_i) begin
            if (in_win) begin
                d.bad = '0;
                if (q.good == GOOD_LAST) begin
                    d.lock = 1'b1;
                end else begin
                    d.good = q.good + GW'(1);
                end
            end else begin
                d.good = '0;
                if (q.bad == BAD_LAST) begin
                    d.lock = 1'b0;
                end else begin
                    d.bad = q.bad + BW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign locked_o = q.lock;

    // R7: lock rises only on a measurement
    a_r7_rise_on_meas: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(locked_o) |-> $past(err_vld_i));

    // R8: lock falls only on a measurement
    a_r8_fall_on_meas: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(locked_o) |-> $past(err_vld_i));

    // R7: a good run and a bad run are never both in progress
    a_r7_runs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(q.good != '0 && q.bad != '0));

endmodule

// File: rtl/ckmul_pll.sv
module ckmul_pll
    import ckmul_pkg::*;
#(
    parameter int              TW_W      = 32,
    parameter int              DIV_N     = 1000,
    parameter logic [TW_W-1:0] NOM_TW    = 32'd137438953,
    parameter int              SAT_CYC   = 15625,
    parameter int              KP_SH     = 11,
    parameter int              KI_SH     = 7,
    parameter int              INT_LIM   = 1 << 24,
    parameter int              THR_W     = 16,
    parameter int              LOCK_GOOD = 16,
    parameter int              LOCK_BAD  = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ref_i,
    input  logic [THR_W-1:0] lock_thresh_i,
    output logic             clk_en_o,
    output logic             fb_pulse_o,
    output logic [TW_W-1:0]  tune_word_o,
    output logic             locked_o
);

    localparam int ERR_W = $clog2(SAT_CYC + 1) + 2;

    logic                    fb_pulse;
    logic                    en_pulse;
    logic                    err_vld;
    logic signed [ERR_W-1:0] err;
    logic [TW_W-1:0]         tw;

    ckmul_refpfd #(
        .SAT_CYC (SAT_CYC),
        .ERR_W   (ERR_W)
    ) pfd_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ref_i      (ref_i),
        .fb_pulse_i (fb_pulse),
        .err_vld_o  (err_vld),
        .err_o      (err)
    );

    ckmul_pi #(
        .TW_W    (TW_W),
        .ERR_W   (ERR_W),
        .NOM_TW  (NOM_TW),
        .KP_SH   (KP_SH),
        .KI_SH   (KI_SH),
        .INT_LIM (INT_LIM)
    ) filt_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .err_vld_i (err_vld),
        .err_i     (err),
        .tw_o      (tw)
    );

    ckmul_nco #(
        .TW_W  (TW_W),
        .DIV_N (DIV_N)
    ) nco_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tw_i    (tw),
        .pulse_o (en_pulse),
        .fb_o    (fb_pulse)
    );

    ckmul_lockmon #(
        .ERR_W     (ERR_W),
        .THR_W     (THR_W),
        .LOCK_GOOD (LOCK_GOOD),
        .LOCK_BAD  (LOCK_BAD)
    ) lock_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .err_vld_i (err_vld),
        .err_i     (err),
        .thresh_i  (lock_thresh_i),
        .locked_o  (locked_o)
    );

    assign clk_en_o    = en_pulse;
    assign fb_pulse_o  = fb_pulse;
    assign tune_word_o = tw;

    // R3: a feedback pulse always rides on an enable
    a_r3_fb_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fb_pulse_o |-> clk_en_o);

    // R6: tuning word and lock change only after a measurement
    a_r6_lock_tw_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tune_word_o != $past(tune_word_o)) |-> $past(err_vld));

endmodule

// File: tb/ckmul_pll_tb.sv
module ckmul_pll_tb_top;

    localparam int      TW_W = 32;
    localparam int      N    = 20;
    localparam int      RP   = 80;
    localparam int      SAT  = 40;
    localparam int      KP   = 22;
    localparam int      KI   = 18;
    localparam int      ILIM = 1 << 26;
    localparam longint  NOM  = (64'd1 << 30) + (64'd1 << 24);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ref_in = 1'b0;
    logic [15:0]     thresh = 16'd3;
    logic            en, fb, lk;
    logic [TW_W-1:0] tw;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    longint cyc = 0;
    int     ph = 0;
    bit     ref_run = 1'b0;
    longint last_ref_ev = -1000;
    int     ref_ev_cnt = 0;
    int     en_since_fb = 0;
    bit     prev_en = 1'b0;
    bit     align_on = 1'b0;
    bit     win_on = 1'b0;
    int     win_en = 0;
    int     win_fb = 0;

    always #2 clk = ~clk;

    ckmul_pll #(
        .TW_W    (TW_W),
        .DIV_N   (N),
        .NOM_TW  (NOM[TW_W-1:0]),
        .SAT_CYC (SAT),
        .KP_SH   (KP),
        .KI_SH   (KI),
        .INT_LIM (ILIM),
        .THR_W   (16)
    ) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .ref_i         (ref_in),
        .lock_thresh_i (thresh),
        .clk_en_o      (en),
        .fb_pulse_o    (fb),
        .tune_word_o   (tw),
        .locked_o      (lk)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor first, then reference generation, in one block
    always @(negedge clk) begin
        if (rst_n) begin
            int tmp;
            tmp = en_since_fb + (en ? 1 : 0);
            if (en) begin
                // R2: enables are never adjacent
                check(!prev_en, "R2 adjacent enable", 1, 0);
            end
            if (fb) begin
                // R3: DIV_N enables per feedback pulse
                check(tmp == N, "R3 enables per feedback", tmp, N);
                en_since_fb = 0;
            end else begin
                en_since_fb = tmp;
            end
            prev_en = en;
            if (win_on) begin
                win_en += en ? 1 : 0;
                win_fb += fb ? 1 : 0;
            end
            if (align_on && fb) begin
                longint dd;
                dd = cyc - last_ref_ev;
                if (dd > RP / 2) dd -= RP;
                // R4 R9: feedback near the zero-error cycle
                check((dd <= 3) && (dd >= -3), "R4/R9 alignment", dd, 0);
            end
        end
        if (ref_run) begin
            if (ph == 0) begin
                ref_in = 1'b1;
                last_ref_ev = cyc + 2;
                ref_ev_cnt++;
            end
            if (ph == RP / 2) ref_in = 1'b0;
            ph = (ph == RP - 1) ? 0 : ph + 1;
        end else begin
            ref_in = 1'b0;
            ph = 0;
        end
    end

    task automatic wait_lock(input int lim, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            step();
            if (lk) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic to_mid_phase();
        do step(); while (ph != RP / 2 + 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        longint prev_tw;
        longint exp_tw;
        longint integ;
        bit ok;

        repeat (5) @(negedge clk);
        // R1: state during reset
        check(tw == NOM[TW_W-1:0], "R1 tuning word in reset", tw, NOM);
        check(!lk && !en && !fb, "R1 outputs in reset", {lk, en, fb}, 0);
        rst_n = 1'b1;
        step();
        check(tw == NOM[TW_W-1:0], "R1 tuning word after reset", tw, NOM);
        check(!lk, "R1 lock after reset", lk, 0);

        // Phase A: no reference, every measurement saturates negative (R5, R6)
        prev_tw = tw;
        for (int k = 1; k <= 7; k++) begin
            int t;
            t = 0;
            while (longint'(tw) == prev_tw && t < 2000) begin
                step();
                t++;
            end
            integ = longint'(k) * SAT * (longint'(1) << KI);
            if (integ > ILIM) integ = ILIM;
            exp_tw = NOM - longint'(SAT) * (longint'(1) << KP) - integ;
            check(longint'(tw) == exp_tw, "R5/R6 saturated update", tw, exp_tw);
            prev_tw = tw;
        end
        repeat (500) step();
        // R6: integrator clamped, word now holds
        check(longint'(tw) == prev_tw, "R6 clamp hold", tw, prev_tw);
        check(!lk, "R7 no lock without reference", lk, 0);

        // Phase B: start reference, pull in and lock
        ref_run = 1'b1;
        repeat (15 * RP) step();
        check(!lk, "R7 lock not before 16 measurements", lk, 0);
        wait_lock(40000, ok);
        check(ok, "R7 lock acquired", ok, 1);
        repeat (40 * RP) step();
        to_mid_phase();
        win_en = 0;
        win_fb = 0;
        win_on = 1'b1;
        align_on = 1'b1;
        repeat (32 * RP) step();
        win_on = 1'b0;
        align_on = 1'b0;
        check(win_fb == 32, "R9 feedback per 32 periods", win_fb, 32);
        check(win_en >= 32 * N - 1 && win_en <= 32 * N + 1, "R9 enables per 32 periods", win_en, 32 * N);
        check(lk, "R9 lock held", lk, 1);

        // Phase C: withdraw reference, lock falls on the fourth bad measurement (R8)
        to_mid_phase();
        ref_run = 1'b0;
        prev_tw = tw;
        for (int k = 1; k <= 4; k++) begin
            int t;
            t = 0;
            while (longint'(tw) == prev_tw && t < 2000) begin
                step();
                t++;
            end
            check(lk == (k < 4), "R8 lock after bad measurement", lk, (k < 4));
            prev_tw = tw;
        end

        // Phase D: relock
        ref_run = 1'b1;
        wait_lock(40000, ok);
        check(ok, "R7 relock", ok, 1);
        repeat (20 * RP) step();

        // Phase E: threshold zero forces unlock after four measurements (R8)
        to_mid_phase();
        thresh = 16'd0;
        repeat (3 * RP) step();
        check(lk, "R8 lock after three bad", lk, 1);
        repeat (RP) step();
        check(!lk, "R8 unlock after four bad", lk, 0);
        thresh = 16'd3;
        wait_lock(40000, ok);
        check(ok, "R7 relock with threshold restored", ok, 1);

        finish_run();
    end

endmodule